// File: doc/BRIEF.md
# Carry-Free Signed-Digit Column Adder

This block is a purely combinational adder. It takes an ordinary binary operand and a redundant operand whose digits may be +1, 0 or -1. It produces a result in the same redundant form. No carry travels further than one column, so the logic depth stays the same at every width. The redundant operand and the result are each carried on two vectors of equal weight. The positive vector marks digits of +1, and the negative vector marks digits of -1. A digit is 0 when neither bit is set.

Each column forms a carry and a flag from its own three input bits. The flag means the column has already counted one more than its true value. The carry arriving from the column to its right then either absorbs that excess, or the column emits a -1 digit. Two extra carry-seed inputs form a column below bit 0. This lets a running total be chained or incremented. Tying the negative input vector to zero turns the block into an adder of two plain binary numbers with a redundant result. Registers, operand sequencing and the final conversion back to binary belong to the surrounding logic.

Top module: `sd_column_adder`

## Requirements
- R1: Digit i of any operand or result is worth (positive bit i) minus (negative bit i). The input pair (b_pos_i[i], b_neg_i[i]) = (1,1) is not a legal input. The outputs never set both sum_pos_o[i] and sum_neg_o[i].
- R2: For every legal input, sum_pos_o - sum_neg_o, read as unsigned vectors of WIDTH+1 bits, equals a_i + b_pos_i - b_neg_i + seed, where seed is 1 when seed_a_i or seed_b_i is 1 and 0 otherwise.
- R3: The top result column WIDTH holds the carry out of column WIDTH-1. That carry is (a_i OR b_pos_i) AND NOT b_neg_i at that column. sum_neg_o[WIDTH] is always 0.
- R4: Column i has flag F = (a XOR b_pos) when b_neg is 0, and F = NOT(a OR b_pos) when b_neg is 1. Call the carry arriving from column i-1 C. Then sum_pos_o[i] = NOT F AND C, and sum_neg_o[i] = F AND NOT C. For example, a_i=1 with all else 0 gives sum_pos_o=...10 and sum_neg_o=...01.
- R5: When b_neg_i is all zero, sum_neg_o[i] for i >= 1 equals F AND NOT a_i[i-1] AND NOT b_pos_i[i-1].
- R6: The carry into column 0 is 1 when exactly one of seed_a_i, seed_b_i is 1, and 0 when both are 0. The case where both are 1 also gives 1.
- R7: An input bit at column j affects only result columns j and j+1. Every other result column stays unchanged when that bit flips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Plain binary operand |
| b_pos_i | input | WIDTH | Redundant operand, +1 digit markers |
| b_neg_i | input | WIDTH | Redundant operand, -1 digit markers |
| seed_a_i | input | 1 | Carry-seed bit one below column 0 |
| seed_b_i | input | 1 | Second carry-seed bit one below column 0 |
| sum_pos_o | output | WIDTH+1 | Result, +1 digit markers |
| sum_neg_o | output | WIDTH+1 | Result, -1 digit markers |

## Verification
A wrong flag or carry in any column shows up at once, in the same evaluation, as a result whose signed value differs from the integer reference. It can also show as a column with both output bits set, or as a change leaking into a column that should not see it. The value is therefore compared on every vector at widths 1, 6, 10 and 32. The bench also flips single input bits and confirms that only the two neighbouring result columns move. Exact bit patterns are pinned down for the cases with a lone digit, where the flag and carry paths can be told apart.

// File: rtl/sd_adder_pkg.sv
package sd_adder_pkg;

  // Per-column generation result: carry toward the next column, and the
  // marker saying the column has pre-counted one unit too many.
  typedef struct packed {
    logic carry;
    logic flag;
  } sd_colgen_t;

endpackage

// File: rtl/sd_col_gen.sv
module sd_col_gen
  import sd_adder_pkg::*;
(
  input  logic       a_bit,
  input  logic       p_bit,
  input  logic       n_bit,
  output sd_colgen_t gen
);

  logic any_one;

  always_comb begin
    any_one   = a_bit | p_bit;
    gen.carry = any_one & ~n_bit;
    // Without a -1 digit: flag when exactly one input is set.
    // With a -1 digit: flag only when the column sums to -1.
    gen.flag  = n_bit ? ~any_one : (a_bit ^ p_bit);
  end

endmodule

// File: rtl/sd_col_digit.sv
module sd_col_digit (
  input  logic flag,
  input  logic carry_in,
  output logic pos,
  output logic neg
);

  always_comb begin
    pos = ~flag & carry_in;
    neg = flag & ~carry_in;
  end

endmodule

// File: rtl/sd_carry_seed.sv
module sd_carry_seed (
  input  logic seed_a,
  input  logic seed_b,
  output logic carry
);

  // The seed column has no negative digit, so its carry follows the
  // ordinary column rule with the -1 marker held low.
  always_comb carry = seed_a | seed_b;

endmodule

// File: rtl/sd_column_adder.sv
module sd_column_adder
  import sd_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_pos_i,
  input  logic [WIDTH-1:0] b_neg_i,
  input  logic             seed_a_i,
  input  logic             seed_b_i,
  output logic [WIDTH:0]   sum_pos_o,
  output logic [WIDTH:0]   sum_neg_o
);

  localparam int OUT_W = WIDTH + 1;

  // carry_chain[i] is the carry entering column i; index WIDTH leaves the top.
  logic       [WIDTH:0]   carry_chain;
  sd_colgen_t [WIDTH-1:0] col_gen;
  logic       [OUT_W-1:0] pos_w;
  logic       [OUT_W-1:0] neg_w;

  sd_carry_seed seed_u (
    .seed_a (seed_a_i),
    .seed_b (seed_b_i),
    .carry  (carry_chain[0])
  );

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_col
    sd_col_gen gen_u (
      .a_bit (a_i[gi]),
      .p_bit (b_pos_i[gi]),
      .n_bit (b_neg_i[gi]),
      .gen   (col_gen[gi])
    );

    assign carry_chain[gi+1] = col_gen[gi].carry;

    sd_col_digit dig_u (
      .flag     (col_gen[gi].flag),
      .carry_in (carry_chain[gi]),
      .pos      (pos_w[gi]),
      .neg      (neg_w[gi])
    );
  end

  // Top column holds only the outgoing carry, always a non-negative digit.
  assign pos_w[WIDTH] = carry_chain[WIDTH];
  assign neg_w[WIDTH] = 1'b0;

  assign sum_pos_o = pos_w;
  assign sum_neg_o = neg_w;

endmodule

// File: rtl/sd_column_adder_chk.sv
module sd_column_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_pos_i,
  input logic [WIDTH-1:0] b_neg_i,
  input logic             seed_a_i,
  input logic             seed_b_i,
  input logic [WIDTH:0]   sum_pos_o,
  input logic [WIDTH:0]   sum_neg_o
);

  logic [63:0] lhs_val;
  logic [63:0] rhs_val;
  logic        top_expect;

  always_comb begin
    lhs_val    = 64'(sum_pos_o) - 64'(sum_neg_o);
    rhs_val    = 64'(a_i) + 64'(b_pos_i) - 64'(b_neg_i) + 64'(seed_a_i | seed_b_i);
    top_expect = (a_i[WIDTH-1] | b_pos_i[WIDTH-1]) & ~b_neg_i[WIDTH-1];

    // R1
    in_digit_legal_chk: assert ((b_pos_i & b_neg_i) == '0);
    // R1
    out_digit_legal_chk: assert ((sum_pos_o & sum_neg_o) == '0);
    // R2
    value_match_chk: assert (lhs_val == rhs_val);
    // R3
    top_digit_chk: assert (sum_neg_o[WIDTH] == 1'b0 && sum_pos_o[WIDTH] == top_expect);
    // R6
    if (a_i == '0 && b_pos_i == '0 && b_neg_i == '0) begin
      seed_only_chk: assert (sum_neg_o == '0 && sum_pos_o == (WIDTH+1)'(seed_a_i | seed_b_i));
    end
  end

endmodule

bind sd_column_adder sd_column_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .a_i       (a_i),
  .b_pos_i   (b_pos_i),
  .b_neg_i   (b_neg_i),
  .seed_a_i  (seed_a_i),
  .seed_b_i  (seed_b_i),
  .sum_pos_o (sum_pos_o),
  .sum_neg_o (sum_neg_o)
);

// File: tb/sd_column_adder_tb_top.sv
module sd_column_adder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] ra, rb, rnb;
  logic        sa, sb;

  logic [10:0] s10, n10;
  logic [1:0]  s1, n1;
  logic [6:0]  s6, n6;
  logic [32:0] s32, n32;

  sd_column_adder #(.WIDTH(10)) dut_i (
    .a_i(ra[9:0]), .b_pos_i(rb[9:0]), .b_neg_i(rnb[9:0]),
    .seed_a_i(sa), .seed_b_i(sb), .sum_pos_o(s10), .sum_neg_o(n10));
  sd_column_adder #(.WIDTH(1)) dut_w1_i (
    .a_i(ra[0:0]), .b_pos_i(rb[0:0]), .b_neg_i(rnb[0:0]),
    .seed_a_i(sa), .seed_b_i(sb), .sum_pos_o(s1), .sum_neg_o(n1));
  sd_column_adder #(.WIDTH(6)) dut_w6_i (
    .a_i(ra[5:0]), .b_pos_i(rb[5:0]), .b_neg_i(rnb[5:0]),
    .seed_a_i(sa), .seed_b_i(sb), .sum_pos_o(s6), .sum_neg_o(n6));
  sd_column_adder #(.WIDTH(32)) dut_w32_i (
    .a_i(ra), .b_pos_i(rb), .b_neg_i(rnb),
    .seed_a_i(sa), .seed_b_i(sb), .sum_pos_o(s32), .sum_neg_o(n32));

  // Stimulus table for the 10-bit instance: a, b_pos, b_neg, {seed_a,seed_b}, value.
  localparam logic [9:0] T_A  [NVEC] = '{10'd0, 10'd45, 10'd1023, 10'd0, 10'd1023,
                                         10'd0, 10'd1023, 10'd0, 10'h155, 10'd512};
  localparam logic [9:0] T_B  [NVEC] = '{10'd0, 10'd19, 10'd1023, 10'd0, 10'd0,
                                         10'b1000011010, 10'b1000011010, 10'd0, 10'h2AA, 10'd512};
  localparam logic [9:0] T_NB [NVEC] = '{10'd0, 10'd0, 10'd0, 10'd1023, 10'd1023,
                                         10'b0010000100, 10'b0010000100, 10'd0, 10'd0, 10'd0};
  localparam logic [1:0] T_SD [NVEC] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
                                         2'b00, 2'b10, 2'b11, 2'b01, 2'b00};
  localparam int         T_EXP[NVEC] = '{0, 64, 2046, -1023, 0,
                                         406, 1430, 1, 1024, 1024};

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [31:0] nb,
                       input logic s_a, input logic s_b);
    @(posedge clk);
    ra = a; rb = b; rnb = nb; sa = s_a; sb = s_b;
    @(negedge clk);
  endtask

  function automatic longint ref_val(input int w);
    longint m;
    m = (longint'(1) << w) - 1;
    return (longint'(ra) & m) + (longint'(rb) & m) - (longint'(rnb) & m) + longint'(sa | sb);
  endfunction

  function automatic longint got_val(input logic [32:0] s, input logic [32:0] n);
    return longint'(s) - longint'(n);
  endfunction

  task automatic check_one(input int w, input logic [32:0] s, input logic [32:0] n);
    logic top_exp;
    top_exp = (ra[w-1] | rb[w-1]) & ~rnb[w-1];
    check(got_val(s, n) == ref_val(w), "R2", $sformatf("value w%0d", w), got_val(s, n), ref_val(w));
    check((s & n) == '0, "R1", $sformatf("digit overlap w%0d", w), longint'(s & n), 0);
    check(n[w] == 1'b0 && s[w] == top_exp, "R3", $sformatf("top column w%0d", w),
          longint'({n[w], s[w]}), longint'({1'b0, top_exp}));
  endtask

  task automatic check_widths();
    check_one(1,  33'(s1),  33'(n1));
    check_one(6,  33'(s6),  33'(n6));
    check_one(10, 33'(s10), 33'(n10));
    check_one(32, s32, n32);
  endtask

  initial begin
    ra = '0; rb = '0; rnb = '0; sa = 1'b0; sb = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);

    // Idle state: all inputs zero gives an all-zero result (R2)
    check(s10 == '0 && n10 == '0, "R2", "idle zero", longint'({s10, n10}), 0);

    // Table walk on the 10-bit instance (R2, R6, worked digit string)
    for (int v = 0; v < NVEC; v++) begin
      drive(32'(T_A[v]), 32'(T_B[v]), 32'(T_NB[v]), T_SD[v][1], T_SD[v][0]);
      check(got_val(33'(s10), 33'(n10)) == longint'(T_EXP[v]), (v >= 6 && v <= 8) ? "R6" : "R2",
            $sformatf("table %0d", v), got_val(33'(s10), 33'(n10)), longint'(T_EXP[v]));
      check_widths();
    end

    // R4: lone +1 in column 0 -> flag there, carry to column 1
    drive(32'd1, 32'd0, 32'd0, 1'b0, 1'b0);
    check(s10 == 11'b10 && n10 == 11'b01, "R4", "lone a bit",
          longint'({s10, n10}), longint'({11'b10, 11'b01}));
    // R4: lone -1 in column 0 -> negative digit, no carry
    drive(32'd0, 32'd0, 32'd1, 1'b0, 1'b0);
    check(s10 == 11'b0 && n10 == 11'b01, "R4", "lone neg digit",
          longint'({s10, n10}), longint'({11'b0, 11'b01}));
    // R4: +1 with seed absorbs flag -> positive digit one column up only
    drive(32'd1, 32'd0, 32'd0, 1'b1, 1'b0);
    check(s10 == 11'b10 && n10 == 11'b0, "R4", "flag absorbed",
          longint'({s10, n10}), longint'({11'b10, 11'b0}));
    // R6: seed combinations with zero operands
    drive(32'd0, 32'd0, 32'd0, 1'b0, 1'b1);
    check(s10 == 11'd1 && n10 == 11'd0, "R6", "seed one", longint'(s10), 1);
    drive(32'd0, 32'd0, 32'd0, 1'b1, 1'b1);
    check(s10 == 11'd1 && n10 == 11'd0, "R6", "seed both", longint'(s10), 1);

    // R5: plain binary operands, negative digit rule
    for (int t = 0; t < 200; t++) begin
      drive($urandom, $urandom, 32'd0, 1'(t), 1'b0);
      for (int i = 1; i < 32; i++) begin
        logic e;
        e = (ra[i] ^ rb[i]) & ~ra[i-1] & ~rb[i-1];
        if (n32[i] != e) check(1'b0, "R5", $sformatf("col %0d", i), longint'(n32[i]), longint'(e));
      end
      check(1'b1, "R5", "nb zero rule", 0, 0);
    end

    // R2/R1/R3: random legal operands at all widths
    for (int t = 0; t < 2000; t++) begin
      logic [31:0] bb;
      bb = $urandom;
      drive($urandom, bb, $urandom & ~bb, 1'($urandom), 1'($urandom));
      check_widths();
    end

    // R7: flipping one input bit moves only columns j and j+1
    for (int t = 0; t < 300; t++) begin
      logic [31:0] bb, a0;
      logic [32:0] ps, pn, keep;
      int j, kind;
      bb = $urandom;
      a0 = $urandom;
      j = int'($urandom % 32);
      kind = int'($urandom % 3);
      drive(a0, bb & ~(32'd1 << j), $urandom & ~bb & ~(32'd1 << j), 1'b0, 1'($urandom));
      ps = s32; pn = n32;
      if (kind == 0)      drive(ra ^ (32'd1 << j), rb, rnb, sa, sb);
      else if (kind == 1) drive(ra, rb | (32'd1 << j), rnb, sa, sb);
      else                drive(ra, rb, rnb | (32'd1 << j), sa, sb);
      keep = ~(33'd3 << j);
      check(((ps ^ s32) & keep) == '0 && ((pn ^ n32) & keep) == '0, "R7",
            $sformatf("locality col %0d", j), longint'(((ps ^ s32) | (pn ^ n32)) & keep), 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule